// File: doc/BRIEF.md
# SDRAM Single-Bank Command Legality Monitor

This block watches the command pins of a single-data-rate SDRAM bus and follows one bank through its short-lived busy states. Each clock it turns the select, row-strobe, column-strobe and write-enable levels into a command code. It keeps a model of the bank's state: idle, row open, precharging, recovering from a write (with or without an automatic close), refreshing, and loading the mode register. Whenever a command arrives that the bank may not accept in its present busy state, it raises a one-clock error strobe and sets a sticky error bit.

The busy states end on their own. Write recovery lasts a programmable number of clocks (`t_dpl`). Refresh lasts `t_rc` clocks. Mode-register loading always lasts two clocks. The monitor is passive: it drives nothing onto the bus, and it is meant to sit beside a controller in simulation or in silicon as a protocol guard.

Top module: `sdram_bank_cmd_checker`

## Requirements
- R1: `cmd_o` shows, one clock after the pins are sampled, the decoded command. Deselect (select high) is 0. With select low, the {row, column, write} strobe levels map as follows: HHH gives NOP 1, HHL gives burst stop 2, HLH gives read 3, HLL gives write 4, LHH gives activate 5, LHL gives precharge 6, LLH gives refresh 7, LLL gives mode load 8.
- R2: While reset is high, and on the first clock after it, `state_o` is idle (0), `illegal_o` is 0 and `err_sticky_o` is 0.
- R3: `state_o` codes are: idle 0, row open 1, write recovery 2, write recovery with auto-close 3, precharging 4, refreshing 5, mode loading 6. From idle, activate opens the row, refresh enters refreshing and mode load enters mode loading. From row open, write enters code 2 (A10 low) or code 3 (A10 high), and precharge enters precharging. Precharging returns to idle after one clock.
- R4: In write recovery, deselect, NOP and burst stop are accepted, and the bank returns to row open after `t_dpl` clocks. A read returns it to row open at once. A new write restarts the recovery time. Activate, precharge, refresh and mode load are flagged.
- R5: In write recovery with auto-close, only deselect, NOP and burst stop are accepted. After `t_dpl` clocks the bank goes to precharging, or to row open if a burst stop was seen.
- R6: In refreshing, deselect, NOP and burst stop are accepted, and the bank returns to idle after `t_rc` clocks. Every other command is flagged.
- R7: Mode loading lasts exactly two clocks and then returns to idle. Only deselect and NOP are accepted there.
- R8: A command is neither checked nor acted on unless CKE is high in both the current and the previous cycle.
- R9: Read, write, activate and single-bank precharge take part only when the bank address equals `BANK_ID`. Precharge with A10 high, refresh and mode load always take part.
- R10: A flagged command leaves the state and the running timer unchanged. `illegal_o` is high for exactly the clock that follows each flagged command.
- R11: `err_sticky_o` rises with the first `illegal_o` pulse and stays high until reset.
- R12: No command is flagged while the bank is idle, row open or precharging.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| cke | input | 1 | Clock enable |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10 (auto-close / all-bank select) |
| t_dpl | input | CNT_W | Write recovery time in clocks |
| t_rc | input | CNT_W | Refresh time in clocks |
| state_o | output | 3 | Tracked bank state code |
| cmd_o | output | 4 | Decoded command code |
| illegal_o | output | 1 | One-clock illegal-command strobe |
| err_sticky_o | output | 1 | Sticky error flag |

## Verification
The bench builds the monitor with `BANK_ID` = 2 and a 4-bit timer width, so it can steer commands to the tracked bank and to a foreign bank (address 1). This exercises both outcomes of the bank-address filter. The recovery and refresh times are driven first as 3 and 4 clocks, then as 1 and 2. At both settings each exit edge falls within a few clocks and can be checked exactly, including the shortest one-clock stay. The narrow timer also keeps the whole nine-command sweep of every busy state short.

// File: rtl/sdram_chk_pkg.sv
package sdram_chk_pkg;

  typedef enum logic [3:0] {
    CMD_DESL  = 4'd0,
    CMD_NOP   = 4'd1,
    CMD_BST   = 4'd2,
    CMD_READ  = 4'd3,
    CMD_WRITE = 4'd4,
    CMD_ACT   = 4'd5,
    CMD_PRE   = 4'd6,
    CMD_REF   = 4'd7,
    CMD_MRS   = 4'd8
  } cmd_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ROWACT = 3'd1,
    ST_WREC   = 3'd2,
    ST_WRAP   = 3'd3,
    ST_PRECH  = 3'd4,
    ST_REFR   = 3'd5,
    ST_MODE   = 3'd6
  } bank_st_e;

  localparam int MODE_CYCLES = 2;

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_chk_pkg::*;
(
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    if (cs_n) begin
      cmd = CMD_DESL;
    end else begin
      case ({ras_n, cas_n, we_n})
        3'b111:  cmd = CMD_NOP;
        3'b110:  cmd = CMD_BST;
        3'b101:  cmd = CMD_READ;
        3'b100:  cmd = CMD_WRITE;
        3'b011:  cmd = CMD_ACT;
        3'b010:  cmd = CMD_PRE;
        3'b001:  cmd = CMD_REF;
        default: cmd = CMD_MRS;
      endcase
    end
  end

endmodule

// File: rtl/sdram_legal_table.sv
module sdram_legal_table
  import sdram_chk_pkg::*;
(
  input  bank_st_e state,
  input  cmd_e     cmd,
  output logic     tracked,
  output logic     legal
);

  always_comb begin
    tracked = 1'b1;
    legal   = 1'b0;
    case (state)
      ST_WREC: legal = (cmd == CMD_DESL) || (cmd == CMD_NOP) || (cmd == CMD_BST) ||
                       (cmd == CMD_READ) || (cmd == CMD_WRITE);
      ST_WRAP: legal = (cmd == CMD_DESL) || (cmd == CMD_NOP) || (cmd == CMD_BST);
      ST_REFR: legal = (cmd == CMD_DESL) || (cmd == CMD_NOP) || (cmd == CMD_BST);
      ST_MODE: legal = (cmd == CMD_DESL) || (cmd == CMD_NOP);
      default: begin
        tracked = 1'b0;
        legal   = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
  import sdram_chk_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             act_en,
  input  logic             legal,
  input  cmd_e             cmd,
  input  logic             a10,
  input  logic [CNT_W-1:0] t_dpl,
  input  logic [CNT_W-1:0] t_rc,
  output bank_st_e         state
);

  localparam logic [CNT_W-1:0] MODE_LOAD = CNT_W'(MODE_CYCLES - 1);

  bank_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             bst_q, bst_d;
  logic             go;
  logic             expired;

  function automatic logic [CNT_W-1:0] load_of(input logic [CNT_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  assign go      = act_en && legal;
  assign expired = (cnt_q == '0);

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    bst_d = bst_q;
    case (st_q)
      ST_IDLE: begin
        if (go && cmd == CMD_ACT) begin
          st_d = ST_ROWACT;
        end else if (go && cmd == CMD_REF) begin
          st_d  = ST_REFR;
          cnt_d = load_of(t_rc);
        end else if (go && cmd == CMD_MRS) begin
          st_d  = ST_MODE;
          cnt_d = MODE_LOAD;
        end
      end
      ST_ROWACT: begin
        if (go && cmd == CMD_WRITE) begin
          st_d  = a10 ? ST_WRAP : ST_WREC;
          cnt_d = load_of(t_dpl);
          bst_d = 1'b0;
        end else if (go && cmd == CMD_PRE) begin
          st_d = ST_PRECH;
        end
      end
      ST_PRECH: st_d = ST_IDLE;
      ST_WREC: begin
        if (go && cmd == CMD_WRITE) begin
          st_d  = a10 ? ST_WRAP : ST_WREC;
          cnt_d = load_of(t_dpl);
          bst_d = 1'b0;
        end else if (go && cmd == CMD_READ) begin
          st_d = ST_ROWACT;
        end else if (expired) begin
          st_d = ST_ROWACT;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_WRAP: begin
        bst_d = bst_q || (go && cmd == CMD_BST);
        if (expired) begin
          st_d = bst_d ? ST_ROWACT : ST_PRECH;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_REFR, ST_MODE: begin
        if (expired) begin
          st_d = ST_IDLE;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      bst_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      bst_q <= bst_d;
    end
  end

  assign state = st_q;

endmodule

// File: rtl/sdram_bank_cmd_checker.sv
module sdram_bank_cmd_checker
  import sdram_chk_pkg::*;
#(
  parameter int BA_W    = 2,
  parameter int BANK_ID = 0,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic             cke,
  input  logic [BA_W-1:0]  ba,
  input  logic             a10,
  input  logic [CNT_W-1:0] t_dpl,
  input  logic [CNT_W-1:0] t_rc,
  output logic [2:0]       state_o,
  output logic [3:0]       cmd_o,
  output logic             illegal_o,
  output logic             err_sticky_o
);

  localparam logic [BA_W-1:0] OWN_BA = BA_W'(BANK_ID);

  cmd_e     cmd_now;
  cmd_e     cmd_q;
  bank_st_e bank_st;
  logic     cke_q;
  logic     relevant;
  logic     act_en;
  logic     tracked;
  logic     legal;
  logic     flag_d;
  logic     illegal_q;
  logic     sticky_q;

  sdram_cmd_decode u_dec (
    .cs_n  (cs_n),
    .ras_n (ras_n),
    .cas_n (cas_n),
    .we_n  (we_n),
    .cmd   (cmd_now)
  );

  sdram_legal_table u_tbl (
    .state   (bank_st),
    .cmd     (cmd_now),
    .tracked (tracked),
    .legal   (legal)
  );

  always_comb begin
    case (cmd_now)
      CMD_READ, CMD_WRITE, CMD_ACT: relevant = (ba == OWN_BA);
      CMD_PRE:                      relevant = a10 || (ba == OWN_BA);
      default:                      relevant = 1'b1;
    endcase
  end

  assign act_en = cke && cke_q && relevant;
  assign flag_d = act_en && tracked && !legal;

  sdram_bank_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk    (clk),
    .rst    (rst),
    .act_en (act_en),
    .legal  (legal),
    .cmd    (cmd_now),
    .a10    (a10),
    .t_dpl  (t_dpl),
    .t_rc   (t_rc),
    .state  (bank_st)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cke_q     <= 1'b0;
      cmd_q     <= CMD_DESL;
      illegal_q <= 1'b0;
      sticky_q  <= 1'b0;
    end else begin
      cke_q     <= cke;
      cmd_q     <= cmd_now;
      illegal_q <= flag_d;
      sticky_q  <= sticky_q || flag_d;
    end
  end

  assign state_o      = bank_st;
  assign cmd_o        = cmd_q;
  assign illegal_o    = illegal_q;
  assign err_sticky_o = sticky_q;

endmodule

// File: rtl/sdram_bank_cmd_checker_sva.sv
module sdram_bank_cmd_checker_sva (
  input logic       clk,
  input logic       rst,
  input logic       cke,
  input logic [2:0] state_o,
  input logic       illegal_o,
  input logic       err_sticky_o
);

  assert_state_code_R3: assert property (@(posedge clk) disable iff (rst)
    state_o <= 3'd6);

  assert_wrap_exit_R5: assert property (@(posedge clk) disable iff (rst)
    ($past(state_o) == 3'd3 && state_o != 3'd3) |-> (state_o == 3'd4 || state_o == 3'd1));

  assert_refresh_exit_R6: assert property (@(posedge clk) disable iff (rst)
    ($past(state_o) == 3'd5 && state_o != 3'd5) |-> state_o == 3'd0);

  assert_mode_first_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd6 && $past(state_o) != 3'd6) |=> state_o == 3'd6);

  assert_mode_second_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd6 && $past(state_o) == 3'd6) |=> state_o == 3'd0);

  assert_cke_gate_R8: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> ($past(cke) && $past(cke, 2)));

  assert_sticky_set_R11: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> err_sticky_o);

  assert_sticky_hold_R11: assert property (@(posedge clk) disable iff (rst)
    err_sticky_o |=> err_sticky_o);

  assert_flag_tracked_R12: assert property (@(posedge clk) disable iff (rst)
    illegal_o |-> ($past(state_o) inside {3'd2, 3'd3, 3'd5, 3'd6}));

endmodule

bind sdram_bank_cmd_checker sdram_bank_cmd_checker_sva u_sva (
  .clk          (clk),
  .rst          (rst),
  .cke          (cke),
  .state_o      (state_o),
  .illegal_o    (illegal_o),
  .err_sticky_o (err_sticky_o)
);

// File: tb/sdram_bank_cmd_checker_tb_top.sv
module sdram_bank_cmd_checker_tb_top;
  import sdram_chk_pkg::*;

  localparam int BA_W  = 2;
  localparam int OWN   = 2;
  localparam int CNT_W = 4;
  localparam logic [BA_W-1:0] OWN_BA   = BA_W'(OWN);
  localparam logic [BA_W-1:0] OTHER_BA = BA_W'(1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic cke = 1'b1;
  logic [BA_W-1:0] ba = OWN_BA;
  logic a10 = 1'b0;
  logic [CNT_W-1:0] t_dpl = 4'd3;
  logic [CNT_W-1:0] t_rc  = 4'd4;
  logic [2:0] state_o;
  logic [3:0] cmd_o;
  logic illegal_o, err_sticky_o;

  always #2 clk = ~clk;

  sdram_bank_cmd_checker #(.BA_W(BA_W), .BANK_ID(OWN), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .cke(cke), .ba(ba), .a10(a10), .t_dpl(t_dpl), .t_rc(t_rc),
    .state_o(state_o), .cmd_o(cmd_o), .illegal_o(illegal_o), .err_sticky_o(err_sticky_o)
  );

  typedef struct {
    bank_st_e st;
    cmd_e     cmd;
    logic     ill;
    int       req;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // Reference legality per busy state (R4, R5, R6, R7)
  function automatic logic ref_ok(bank_st_e s, cmd_e c);
    case (s)
      ST_WREC: return c inside {CMD_DESL, CMD_NOP, CMD_BST, CMD_READ, CMD_WRITE};
      ST_WRAP: return c inside {CMD_DESL, CMD_NOP, CMD_BST};
      ST_REFR: return c inside {CMD_DESL, CMD_NOP, CMD_BST};
      ST_MODE: return c inside {CMD_DESL, CMD_NOP};
      default: return 1'b1;
    endcase
  endfunction

  task automatic check(input logic ok, input int req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL R%0d actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Driver: put one command on the pins and push the expected outcome
  task automatic full(input cmd_e c, input logic [BA_W-1:0] b, input logic a,
                      input logic ck, input bank_st_e st, input logic ill, input int req);
    exp_t it;
    @(negedge clk);
    cke = ck; ba = b; a10 = a;
    cs_n = (c == CMD_DESL);
    case (c)
      CMD_NOP:   {ras_n, cas_n, we_n} = 3'b111;
      CMD_BST:   {ras_n, cas_n, we_n} = 3'b110;
      CMD_READ:  {ras_n, cas_n, we_n} = 3'b101;
      CMD_WRITE: {ras_n, cas_n, we_n} = 3'b100;
      CMD_ACT:   {ras_n, cas_n, we_n} = 3'b011;
      CMD_PRE:   {ras_n, cas_n, we_n} = 3'b010;
      CMD_REF:   {ras_n, cas_n, we_n} = 3'b001;
      CMD_MRS:   {ras_n, cas_n, we_n} = 3'b000;
      default:   {ras_n, cas_n, we_n} = 3'b111;
    endcase
    it.st = st; it.cmd = c; it.ill = ill; it.req = req;
    sb.push_back(it);
  endtask

  task automatic go(input cmd_e c, input bank_st_e st, input logic ill, input int req);
    full(c, OWN_BA, 1'b0, 1'b1, st, ill, req);
  endtask

  task automatic goa(input cmd_e c, input logic a, input bank_st_e st, input int req);
    full(c, OWN_BA, a, 1'b1, st, 1'b0, req);
  endtask

  // Monitor: one expected item per clock, sampled after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t it;
        it = sb.pop_front();
        n_chk++;
        if (state_o != it.st || cmd_o != it.cmd || illegal_o != it.ill) begin
          n_fail++;
          $display("FAIL R%0d actual st=%0d cmd=%0d ill=%0d expected st=%0d cmd=%0d ill=%0d",
                   it.req, state_o, cmd_o, illegal_o, it.st, it.cmd, it.ill);
        end
      end
    end
  end

  // R6 table sweep: tRC = 4
  task automatic refresh_case(input cmd_e c);
    go(CMD_REF, ST_REFR, 1'b0, 6);
    go(c, ST_REFR, !ref_ok(ST_REFR, c), 6);
    go(CMD_NOP, ST_REFR, 1'b0, 6);
    go(CMD_NOP, ST_REFR, 1'b0, 6);
    go(CMD_NOP, ST_IDLE, 1'b0, 6);
  endtask

  // R7 table sweep
  task automatic mode_case(input cmd_e c);
    go(CMD_MRS, ST_MODE, 1'b0, 7);
    go(c, ST_MODE, !ref_ok(ST_MODE, c), 7);
    go(CMD_NOP, ST_IDLE, 1'b0, 7);
  endtask

  // R4 / R10 table sweep: tDPL = 3
  task automatic wrec_case(input cmd_e c);
    go(CMD_ACT, ST_ROWACT, 1'b0, 3);
    goa(CMD_WRITE, 1'b0, ST_WREC, 4);
    if (c == CMD_READ) begin
      go(CMD_READ, ST_ROWACT, 1'b0, 4);
    end else if (c == CMD_WRITE) begin
      go(CMD_WRITE, ST_WREC, 1'b0, 4);
      go(CMD_NOP, ST_WREC, 1'b0, 4);
      go(CMD_NOP, ST_WREC, 1'b0, 4);
      go(CMD_NOP, ST_ROWACT, 1'b0, 4);
    end else begin
      go(c, ST_WREC, !ref_ok(ST_WREC, c), 10);
      go(CMD_NOP, ST_WREC, 1'b0, 10);
      go(CMD_NOP, ST_ROWACT, 1'b0, 4);
    end
    go(CMD_PRE, ST_PRECH, 1'b0, 3);
    go(CMD_NOP, ST_IDLE, 1'b0, 3);
  endtask

  // R5 table sweep: tDPL = 3
  task automatic wrap_case(input cmd_e c);
    go(CMD_ACT, ST_ROWACT, 1'b0, 3);
    goa(CMD_WRITE, 1'b1, ST_WRAP, 5);
    go(c, ST_WRAP, !ref_ok(ST_WRAP, c), 5);
    go(CMD_NOP, ST_WRAP, 1'b0, 5);
    if (c == CMD_BST) begin
      go(CMD_NOP, ST_ROWACT, 1'b0, 5);
      go(CMD_PRE, ST_PRECH, 1'b0, 3);
    end else begin
      go(CMD_NOP, ST_PRECH, 1'b0, 5);
    end
    go(CMD_NOP, ST_IDLE, 1'b0, 3);
  endtask

  initial begin
    // R2: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(state_o == 3'd0, 2, state_o, 0);
    check(illegal_o == 1'b0, 2, illegal_o, 0);
    check(err_sticky_o == 1'b0, 2, err_sticky_o, 0);
    rst = 1'b0;
    go(CMD_NOP, ST_IDLE, 1'b0, 2);

    // R12: nothing flagged while idle; R1 codes compared on every vector
    go(CMD_READ, ST_IDLE, 1'b0, 12);
    go(CMD_PRE, ST_IDLE, 1'b0, 12);
    go(CMD_BST, ST_IDLE, 1'b0, 12);
    go(CMD_DESL, ST_IDLE, 1'b0, 1);
    @(negedge clk);
    check(err_sticky_o == 1'b0, 11, err_sticky_o, 0);  // R11 before any flag

    for (int i = 0; i < 9; i++) refresh_case(cmd_e'(i));
    for (int i = 0; i < 9; i++) mode_case(cmd_e'(i));
    for (int i = 0; i < 9; i++) wrec_case(cmd_e'(i));
    for (int i = 0; i < 9; i++) wrap_case(cmd_e'(i));

    // R9: bank filter in refreshing and in write recovery
    go(CMD_REF, ST_REFR, 1'b0, 9);
    full(CMD_ACT, OTHER_BA, 1'b0, 1'b1, ST_REFR, 1'b0, 9);
    full(CMD_PRE, OTHER_BA, 1'b1, 1'b1, ST_REFR, 1'b1, 9);
    full(CMD_MRS, OTHER_BA, 1'b0, 1'b1, ST_REFR, 1'b1, 9);
    go(CMD_NOP, ST_IDLE, 1'b0, 9);
    go(CMD_ACT, ST_ROWACT, 1'b0, 9);
    goa(CMD_WRITE, 1'b0, ST_WREC, 9);
    full(CMD_READ, OTHER_BA, 1'b0, 1'b1, ST_WREC, 1'b0, 9);
    full(CMD_WRITE, OTHER_BA, 1'b0, 1'b1, ST_WREC, 1'b0, 9);
    go(CMD_NOP, ST_ROWACT, 1'b0, 9);
    go(CMD_PRE, ST_PRECH, 1'b0, 9);
    go(CMD_NOP, ST_IDLE, 1'b0, 9);

    // R8: CKE low in this or the previous cycle suppresses the check
    go(CMD_REF, ST_REFR, 1'b0, 8);
    full(CMD_MRS, OWN_BA, 1'b0, 1'b0, ST_REFR, 1'b0, 8);
    full(CMD_MRS, OWN_BA, 1'b0, 1'b1, ST_REFR, 1'b0, 8);
    full(CMD_MRS, OWN_BA, 1'b0, 1'b1, ST_REFR, 1'b1, 8);
    go(CMD_NOP, ST_IDLE, 1'b0, 8);

    // Second timing setting: tDPL = 1, tRC = 2 (R4, R5, R6, R7)
    @(negedge clk);
    t_dpl = 4'd1;
    t_rc  = 4'd2;
    go(CMD_NOP, ST_IDLE, 1'b0, 6);
    go(CMD_REF, ST_REFR, 1'b0, 6);
    go(CMD_NOP, ST_REFR, 1'b0, 6);
    go(CMD_NOP, ST_IDLE, 1'b0, 6);
    go(CMD_ACT, ST_ROWACT, 1'b0, 3);
    goa(CMD_WRITE, 1'b0, ST_WREC, 4);
    go(CMD_NOP, ST_ROWACT, 1'b0, 4);
    goa(CMD_WRITE, 1'b1, ST_WRAP, 5);
    go(CMD_NOP, ST_PRECH, 1'b0, 5);
    go(CMD_NOP, ST_IDLE, 1'b0, 5);
    go(CMD_MRS, ST_MODE, 1'b0, 7);
    go(CMD_NOP, ST_MODE, 1'b0, 7);
    go(CMD_NOP, ST_IDLE, 1'b0, 7);

    repeat (3) @(negedge clk);
    check(err_sticky_o == 1'b1, 11, err_sticky_o, 1);  // R11 held after flags
    check(sb.size() == 0, 10, sb.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog (R1) actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule